// File: doc/BRIEF.md
# Searchable Pipeline Instruction Buffer

This block is a queue of decoded instruction templates placed between the decode and execute stages of an in-order pipeline. Each slot holds an opaque template payload whose width is a parameter, plus an optional destination register name with a flag that says whether the name is meaningful. The consumer sees the oldest template at the head and pops it with a dequeue request. The producer pushes a new template with an enqueue request.

A combinational lookup port takes a register name and reports whether any live slot is going to write that register. Decode uses this result to decide whether to stall. A flush input drops every slot when a branch is redirected. Within one cycle the operations act in a fixed order: dequeue first, then lookup, then enqueue, then flush. So a full buffer that drains its head can take a new entry in the same cycle, and the lookup never reports the slot that is leaving.

Top module: `instr_sbuf`

## Requirements
- R1: After synchronous active-high reset the buffer is empty: `first_valid` is 0, `enq_ready` is 1 and `find_hit` is 0.
- R2: Entries leave in the order they arrived; while `first_valid` is 1, `first_payload`, `first_has_dst` and `first_dst` show the oldest entry.
- R3: `enq_ready` is 1 when fewer than DEPTH entries are held, and also when the buffer is full but a dequeue takes effect in the same cycle; in that case the new entry is stored.
- R4: An enqueue request while `enq_ready` is 0 is dropped and the occupancy never exceeds DEPTH.
- R5: A dequeue request while the buffer is empty has no effect.
- R6: `find_hit` is 1 exactly when some held entry has its destination flag at 1 and a stored destination equal to `find_reg`.
- R7: An entry that is dequeued in the current cycle does not make `find_hit` 1 in that cycle.
- R8: An entry that is enqueued in the current cycle does not make `find_hit` 1 in that cycle; it can match from the next cycle on.
- R9: `flush` empties the buffer at the next edge and overrides any enqueue or dequeue in the same cycle; no entry enqueued in that cycle is kept.
- R10: The head outputs show the state before any same-cycle enqueue: an enqueue into an empty buffer leaves `first_valid` at 0 until the next cycle.
- R11: An entry stored with `enq_has_dst` at 0 never matches, whatever its destination bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Request to push a template |
| enq_payload | input | PAYLOAD_W | Template payload to push |
| enq_has_dst | input | 1 | 1 when the pushed template writes a register |
| enq_dst | input | REG_W | Destination register name of the pushed template |
| enq_ready | output | 1 | Push is accepted this cycle |
| deq_req | input | 1 | Request to pop the head entry |
| first_valid | output | 1 | Buffer holds at least one entry |
| first_payload | output | PAYLOAD_W | Payload of the oldest entry |
| first_has_dst | output | 1 | Destination flag of the oldest entry |
| first_dst | output | REG_W | Destination name of the oldest entry |
| find_reg | input | REG_W | Register name to look up |
| find_hit | output | 1 | Some remaining entry writes `find_reg` |
| flush | input | 1 | Drop every entry |

## Verification
The bench builds the buffer with DEPTH 3, REG_W 4 and an 8-bit payload. A depth that is not a power of two drives the pointer wrap through its explicit compare path, and three slots let the full-with-drain case, the pop-while-searching case and the wrap all occur within a few cycles. Destination and lookup names are drawn from a four-name subset so that random traffic produces frequent matches, near misses on entries without a destination, and hits on entries that are leaving.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   // Index width for an array of n slots (at least one bit).
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of an occupancy counter that can hold 0..n.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
   import sbuf_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = idx_bits(DEPTH),
   localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enq_req,
   input  logic             deq_req,
   input  logic             flush,
   output logic             enq_fire,
   output logic             deq_fire,
   output logic             enq_ready,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [CNT_W-1:0] occ
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [PTR_W-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] occ_q;

   // Dequeue acts first, so a full buffer can take a push when it drains.
   assign deq_fire  = deq_req && (occ_q != '0);
   assign enq_ready = (occ_q != FULL) || deq_fire;
   assign enq_fire  = enq_req && enq_ready && !flush;

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_free
         assign rd_nxt = rd_q + 1'b1;
         assign wr_nxt = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_q == LAST) ? '0 : rd_q + 1'b1;
         assign wr_nxt = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         occ_q <= '0;
      end else begin
         if (deq_fire) rd_q <= rd_nxt;
         if (enq_fire) wr_q <= wr_nxt;
         occ_q <= occ_q + CNT_W'(enq_fire) - CNT_W'(deq_fire);
      end
   end

   assign rd_ptr = rd_q;
   assign wr_ptr = wr_q;
   assign occ    = occ_q;

endmodule

// File: rtl/sbuf_store.sv
module sbuf_store
   import sbuf_pkg::*;
#(
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned PAYLOAD_W = 32,
   parameter int unsigned REG_W     = 5,
   localparam int unsigned PTR_W    = idx_bits(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   flush,
   input  logic                   wr_en,
   input  logic [PTR_W-1:0]       wr_ptr,
   input  logic [PAYLOAD_W-1:0]   wr_payload,
   input  logic                   wr_has_dst,
   input  logic [REG_W-1:0]       wr_dst,
   input  logic                   rd_pop,
   input  logic [PTR_W-1:0]       rd_ptr,
   output logic [PAYLOAD_W-1:0]   rd_payload,
   output logic                   rd_has_dst,
   output logic [REG_W-1:0]       rd_dst,
   output logic [DEPTH-1:0]       slot_live,
   output logic [DEPTH-1:0]       slot_has_dst,
   output logic [DEPTH*REG_W-1:0] slot_dst
);

   logic [DEPTH*PAYLOAD_W-1:0] slot_pay;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic                 live_r;
         logic                 has_r;
         logic [REG_W-1:0]     dst_r;
         logic [PAYLOAD_W-1:0] pay_r;
         logic                 hit_wr, hit_rd;

         assign hit_wr = wr_en  && (wr_ptr == PTR_W'(i));
         assign hit_rd = rd_pop && (rd_ptr == PTR_W'(i));

         // A push into the slot being popped (full and draining) wins.
         always_ff @(posedge clk) begin
            if (rst || flush)  live_r <= 1'b0;
            else if (hit_wr)   live_r <= 1'b1;
            else if (hit_rd)   live_r <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (hit_wr) begin
               has_r <= wr_has_dst;
               dst_r <= wr_dst;
               pay_r <= wr_payload;
            end
         end

         assign slot_live[i]                        = live_r;
         assign slot_has_dst[i]                     = has_r;
         assign slot_dst[i*REG_W +: REG_W]          = dst_r;
         assign slot_pay[i*PAYLOAD_W +: PAYLOAD_W]  = pay_r;
      end
   endgenerate

   always_comb begin
      rd_payload = '0;
      rd_has_dst = 1'b0;
      rd_dst     = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_ptr == PTR_W'(i)) begin
            rd_payload = slot_pay[i*PAYLOAD_W +: PAYLOAD_W];
            rd_has_dst = slot_has_dst[i];
            rd_dst     = slot_dst[i*REG_W +: REG_W];
         end
      end
   end

endmodule

// File: rtl/sbuf_match.sv
module sbuf_match
   import sbuf_pkg::*;
#(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned REG_W  = 5,
   localparam int unsigned PTR_W = idx_bits(DEPTH)
) (
   input  logic [DEPTH-1:0]       slot_live,
   input  logic [DEPTH-1:0]       slot_has_dst,
   input  logic [DEPTH*REG_W-1:0] slot_dst,
   input  logic                   pop,
   input  logic [PTR_W-1:0]       head,
   input  logic [REG_W-1:0]       query,
   output logic                   hit
);

   logic [DEPTH-1:0] slot_hit;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
         logic leaving;
         assign leaving     = pop && (head == PTR_W'(i));
         assign slot_hit[i] = slot_live[i] && slot_has_dst[i] && !leaving &&
                              (slot_dst[i*REG_W +: REG_W] == query);
      end
   endgenerate

   assign hit = |slot_hit;

endmodule

// File: rtl/instr_sbuf.sv
module instr_sbuf
   import sbuf_pkg::*;
#(
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned PAYLOAD_W = 32,
   parameter int unsigned REG_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 enq_valid,
   input  logic [PAYLOAD_W-1:0] enq_payload,
   input  logic                 enq_has_dst,
   input  logic [REG_W-1:0]     enq_dst,
   output logic                 enq_ready,
   input  logic                 deq_req,
   output logic                 first_valid,
   output logic [PAYLOAD_W-1:0] first_payload,
   output logic                 first_has_dst,
   output logic [REG_W-1:0]     first_dst,
   input  logic [REG_W-1:0]     find_reg,
   output logic                 find_hit,
   input  logic                 flush
);

   localparam int unsigned PTR_W = idx_bits(DEPTH);
   localparam int unsigned CNT_W = cnt_bits(DEPTH);

   generate
      if (DEPTH < 1)     begin : g_bad_depth $error("instr_sbuf: DEPTH must be >= 1"); end
      if (PAYLOAD_W < 1) begin : g_bad_pay   $error("instr_sbuf: PAYLOAD_W must be >= 1"); end
      if (REG_W < 1)     begin : g_bad_reg   $error("instr_sbuf: REG_W must be >= 1"); end
   endgenerate

   logic                   enq_fire, deq_fire;
   logic [PTR_W-1:0]       rd_ptr, wr_ptr;
   logic [CNT_W-1:0]       occ;
   logic [DEPTH-1:0]       slot_live, slot_has_dst;
   logic [DEPTH*REG_W-1:0] slot_dst;

   sbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst(rst), .enq_req(enq_valid), .deq_req(deq_req), .flush(flush),
      .enq_fire(enq_fire), .deq_fire(deq_fire), .enq_ready(enq_ready),
      .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .occ(occ)
   );

   sbuf_store #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .REG_W(REG_W)) u_store (
      .clk(clk), .rst(rst), .flush(flush),
      .wr_en(enq_fire), .wr_ptr(wr_ptr), .wr_payload(enq_payload),
      .wr_has_dst(enq_has_dst), .wr_dst(enq_dst),
      .rd_pop(deq_fire), .rd_ptr(rd_ptr),
      .rd_payload(first_payload), .rd_has_dst(first_has_dst), .rd_dst(first_dst),
      .slot_live(slot_live), .slot_has_dst(slot_has_dst), .slot_dst(slot_dst)
   );

   sbuf_match #(.DEPTH(DEPTH), .REG_W(REG_W)) u_match (
      .slot_live(slot_live), .slot_has_dst(slot_has_dst), .slot_dst(slot_dst),
      .pop(deq_fire), .head(rd_ptr), .query(find_reg), .hit(find_hit)
   );

   assign first_valid = (occ != '0);

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned PW    = 32,
   parameter int unsigned CW    = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          enq_valid,
   input logic [PW-1:0] enq_payload,
   input logic          deq_req,
   input logic          flush,
   input logic          first_valid,
   input logic [PW-1:0] first_payload,
   input logic          enq_ready,
   input logic          find_hit,
   input logic [CW-1:0] occ
);

   assert_drain_accept_R3: assert property (@(posedge clk) disable iff (rst)
      (deq_req && first_valid) |-> enq_ready);

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
      occ <= CW'(DEPTH));

   assert_full_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      (occ == CW'(DEPTH) && !deq_req) |-> !enq_ready);

   assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
      (!first_valid && !enq_valid) |=> !first_valid);

   assert_leaving_nomatch_R7: assert property (@(posedge clk) disable iff (rst)
      (occ == CW'(1) && deq_req) |-> !find_hit);

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!first_valid && !find_hit));

   assert_head_late_R10: assert property (@(posedge clk) disable iff (rst)
      (!first_valid && enq_valid && !flush) |=>
         (first_valid && first_payload == $past(enq_payload)));

endmodule

bind instr_sbuf sbuf_checker #(.DEPTH(DEPTH), .PW(PAYLOAD_W), .CW(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_payload(enq_payload),
   .deq_req(deq_req), .flush(flush), .first_valid(first_valid),
   .first_payload(first_payload), .enq_ready(enq_ready), .find_hit(find_hit),
   .occ(occ)
);

// File: tb/tb_instr_sbuf.sv
`timescale 1ns/1ps
module tb_instr_sbuf;
   localparam int DEPTH = 3;
   localparam int PW    = 8;
   localparam int RW    = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst;
   logic          enq_valid, enq_has_dst, enq_ready, deq_req, flush;
   logic [PW-1:0] enq_payload, first_payload;
   logic [RW-1:0] enq_dst, first_dst, find_reg;
   logic          first_valid, first_has_dst, find_hit;

   instr_sbuf #(.DEPTH(DEPTH), .PAYLOAD_W(PW), .REG_W(RW)) dut (
      .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_payload(enq_payload),
      .enq_has_dst(enq_has_dst), .enq_dst(enq_dst), .enq_ready(enq_ready),
      .deq_req(deq_req), .first_valid(first_valid), .first_payload(first_payload),
      .first_has_dst(first_has_dst), .first_dst(first_dst),
      .find_reg(find_reg), .find_hit(find_hit), .flush(flush)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   // Reference model: index 0 is the oldest entry.
   logic [PW-1:0] m_pay [DEPTH];
   logic          m_hd  [DEPTH];
   logic [RW-1:0] m_dst [DEPTH];
   int            m_cnt;

   function automatic bit exp_hit(input bit popping, input logic [RW-1:0] q);
      for (int i = (popping ? 1 : 0); i < m_cnt; i++)
         if (m_hd[i] && m_dst[i] == q) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string req, input string tag,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
      end
   endtask

   task automatic step(input bit e, input logic [PW-1:0] p, input bit hd,
                       input logic [RW-1:0] d, input bit dq,
                       input logic [RW-1:0] q, input bit fl, input string tag);
      bit popping, rdy, h;
      @(negedge clk);
      enq_valid = e; enq_payload = p; enq_has_dst = hd; enq_dst = d;
      deq_req = dq; find_reg = q; flush = fl;
      #2;
      popping = dq && (m_cnt > 0);
      rdy     = (m_cnt < DEPTH) || popping;
      h       = exp_hit(popping, q);
      chk(first_valid == (m_cnt > 0), "R2", tag, first_valid, m_cnt > 0);
      if (m_cnt > 0) begin
         chk(first_payload == m_pay[0], "R2", tag, first_payload, m_pay[0]);
         chk(first_has_dst == m_hd[0] && first_dst == m_dst[0], "R2", tag,
             {first_has_dst, first_dst}, {m_hd[0], m_dst[0]});
      end
      chk(enq_ready == rdy, "R3", tag, enq_ready, rdy);
      chk(find_hit == h, "R6", tag, find_hit, h);
      if (fl) m_cnt = 0;
      else begin
         if (popping) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
               m_pay[i] = m_pay[i+1]; m_hd[i] = m_hd[i+1]; m_dst[i] = m_dst[i+1];
            end
            m_cnt--;
         end
         if (e && rdy) begin
            m_pay[m_cnt] = p; m_hd[m_cnt] = hd; m_dst[m_cnt] = d; m_cnt++;
         end
      end
   endtask

   task automatic idle(input logic [RW-1:0] q, input string tag);
      step(0, '0, 0, '0, 0, q, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1; enq_valid = 0; enq_payload = '0; enq_has_dst = 0; enq_dst = '0;
      deq_req = 0; find_reg = '0; flush = 0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      #2;
      chk(!first_valid && enq_ready && !find_hit, "R1", "reset",
          {first_valid, enq_ready, find_hit}, 3'b010);

      // R10: push into empty, head stays invalid this cycle
      step(1, 8'hA5, 1, 4'd2, 0, 4'd2, 0, "R10 push empty");
      idle(4'd2, "R2 head after push");
      step(1, 8'h3C, 1, 4'd3, 0, 4'd0, 0, "R2 fill");
      step(1, 8'h77, 0, 4'd1, 0, 4'd1, 0, "R2 fill");
      // R4: full, push without pop dropped
      step(1, 8'hEE, 1, 4'd9, 0, 4'd9, 0, "R4 full push");
      idle(4'd9, "R4 dropped entry absent");
      // R3: full, pop and push together; R8 new entry not searchable yet
      step(1, 8'h5A, 1, 4'd7, 1, 4'd7, 0, "R3 R8 drain and push");
      idle(4'd7, "R8 visible next cycle");
      // R11: entry without destination (8'h77, dst 1) never matches
      idle(4'd1, "R11 no-dst entry");
      // R7: pop head (dst 3) while looking it up
      step(0, '0, 0, '0, 1, 4'd3, 0, "R7 leaving head");
      step(0, '0, 0, '0, 1, 4'd1, 0, "R11 pop no-dst");
      step(0, '0, 0, '0, 1, 4'd7, 0, "R7 last entry leaving");
      // R5: pop on empty ignored
      step(0, '0, 0, '0, 1, 4'd7, 0, "R5 pop empty");
      idle(4'd7, "R5 still empty");
      // R9: flush beats push and pop
      step(1, 8'h11, 1, 4'd4, 0, 4'd0, 0, "R9 setup");
      step(1, 8'h22, 1, 4'd5, 0, 4'd0, 0, "R9 setup");
      step(1, 8'h33, 1, 4'd6, 1, 4'd5, 1, "R9 flush with push and pop");
      idle(4'd6, "R9 empty after flush");
      idle(4'd5, "R9 empty after flush");

      // Constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int phase;
         bit e, dq, fl;
         phase = (n / 200) % 3;
         e  = ($urandom % 4) < (phase == 0 ? 3 : (phase == 1 ? 2 : 1));
         dq = ($urandom % 4) < (phase == 0 ? 1 : (phase == 1 ? 2 : 3));
         fl = ($urandom % 25) == 0;
         step(e, PW'($urandom), 1'($urandom), RW'($urandom % 4), dq,
              RW'($urandom % 4), fl, "random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule